// File: doc/BRIEF.md
# ADC Pacer Clock and Burst Controller

This block paces an analog-to-digital converter. It divides the system clock by a fixed prescaler twice. The first stage gives a fast counting strobe. The second stage gives a low-rate square reference. Two programmable rate counters in cascade divide the fast strobe again. Each output pulse of the second counter is a pacer tick, and each tick starts a conversion. An external gate pin can be given control of both pacer counters, so pacing can be held off from outside. A third, auxiliary counter channel counts rising edges of an external clock pin. Optionally that pin is first ANDed with the internal reference, so a pin left high lets the reference through.

In burst mode, every pacer tick opens a run of conversions whose length is programmable. Inside the run, the next start is issued only once the converter has raised and then dropped its busy line. A tick that lands while a run is still in progress is dropped and recorded in a sticky overrun flag. A single write port loads the control byte and the three divisors. The external pins are asynchronous and are synchronized inside the block.

Top module: `adc_pacer_burst`

## Requirements
- R1: After reset `conv_start`, `aux_tick` and `overrun` are all 0.
- R2: With burst mode off (control bit 2 = 0), each pacer tick gives exactly one single-cycle `conv_start` pulse. Consecutive pulses are PRESCALE × A × B clocks apart, where A is the divisor at address 1 and B the divisor at address 2. A divisor of 0 counts as 65536.
- R3: With burst mode on and single-ended inputs (bit 2 = 1, bit 3 = 0), each tick gives N+1 conversions, where N is the 4-bit length code in control bits 7:4.
- R4: With burst mode on and differential inputs (bit 3 = 1), a tick gives min(N+1, 8) conversions.
- R5: Inside a burst, a new `conv_start` is never issued while `conv_busy` is high. The next one follows only after busy has been seen high and then low.
- R6: A pacer tick that arrives while a burst is still running sets `overrun` and starts nothing. `overrun` stays set until the next write to the control byte (address 0), which clears it.
- R7: While burst mode is off, the length code in bits 7:4 has no effect: one conversion per tick.
- R8: With control bit 1 = 1, a low `ext_gate_in` holds both pacer counters and no conversions start. Raising it reloads the counters, and pacing resumes at the full period.
- R9: With control bit 1 = 0, both pacer gates are held high and `ext_gate_in` is ignored.
- R10: With control bit 0 = 1 and `ext_clk_in` high, the auxiliary counter counts the internal reference. `aux_tick` pulses every PRESCALE² × C clocks, where C is the divisor at address 3.
- R11: With control bit 0 = 0, the auxiliary counter counts only rising edges of `ext_clk_in`. A pin held steady gives no `aux_tick`.
- R12: With control bit 0 = 1 and `ext_clk_in` low, the reference is blocked and `aux_tick` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 divisor A, 2 divisor B, 3 auxiliary divisor |
| wr_data | input | CNT_W | Write data; control uses bits 7:0 |
| ext_clk_in | input | 1 | Asynchronous auxiliary clock pin, idles high |
| ext_gate_in | input | 1 | Asynchronous pacer gate pin, idles high |
| conv_busy | input | 1 | Converter busy handshake |
| conv_start | output | 1 | Single-cycle conversion start |
| aux_tick | output | 1 | Single-cycle auxiliary counter output pulse |
| overrun | output | 1 | Sticky flag: a tick was dropped during a burst |

## Verification
The handshake properties assume that the converter raises `conv_busy` at some point after each start, and that it never holds busy high when a burst begins. The bench's converter model raises busy in the same cycle as every start and drops it five cycles later. The bench keeps the pacer period well above the longest burst, except in the one scenario that is meant to provoke an overrun. The counter properties assume that counting strobes are never back to back. The external pins change only at a slow rate compared with the clock, so each pin edge yields exactly one strobe after synchronization.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    localparam int LEN_W = 4;

    typedef struct packed {
        logic [LEN_W-1:0] burst_len;
        logic             diff_mode;
        logic             burst_en;
        logic             gate_ext;
        logic             aux_ref_and;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAIT_HI,
        SEQ_WAIT_LO
    } seq_state_e;

    localparam logic [1:0] ADDR_CTRL    = 2'd0;
    localparam logic [1:0] ADDR_DIV_A   = 2'd1;
    localparam logic [1:0] ADDR_DIV_B   = 2'd2;
    localparam logic [1:0] ADDR_DIV_AUX = 2'd3;

endpackage

// File: rtl/pacer_sync2.sv
module pacer_sync2 #(
    parameter int               WIDTH     = 1,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = d;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.meta   <= RESET_VAL;
            s_q.stable <= RESET_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign q = s_q.stable;

endmodule

// File: rtl/pacer_timebase.sv
module pacer_timebase #(
    parameter int PRESCALE = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic fast_stb,
    output logic ref_level
);

    localparam int              PS_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] LAST_V = PS_W'(PRESCALE - 1);
    localparam logic [PS_W-1:0] HALF_V = PS_W'(PRESCALE / 2);

    typedef struct packed {
        logic [PS_W-1:0] div1;
        logic [PS_W-1:0] div2;
        logic            stb;
        logic            ref_lvl;
    } tb_t;

    tb_t tb_d, tb_q;

    always_comb begin
        tb_d     = tb_q;
        tb_d.stb = 1'b0;
        if (tb_q.div1 == LAST_V) begin
            tb_d.div1 = '0;
            tb_d.stb  = 1'b1;
        end else begin
            tb_d.div1 = tb_q.div1 + 1'b1;
        end
        if (tb_q.stb) begin
            tb_d.div2 = (tb_q.div2 == LAST_V) ? '0 : tb_q.div2 + 1'b1;
        end
        tb_d.ref_lvl = (tb_d.div2 < HALF_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= '{div1: '0, div2: '0, stb: 1'b0, ref_lvl: 1'b1};
        end else begin
            tb_q <= tb_d;
        end
    end

    assign fast_stb  = tb_q.stb;
    assign ref_level = tb_q.ref_lvl;

    // R2: the fast strobe is a single-cycle pulse
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        tb_q.stb |=> !tb_q.stb);

    // R10: the reference only moves on a fast strobe
    a_r10_ref_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_q.stb |=> $stable(tb_q.div2));

endmodule

// File: rtl/pacer_rate_counter.sv
module pacer_rate_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             gate,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             pulse
);

    localparam int             C_W    = CNT_W + 1;
    localparam logic [C_W-1:0] FULL_V = C_W'(1) << CNT_W;
    localparam logic [C_W-1:0] ONE_V  = C_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic [C_W-1:0]   count;
        logic             gate_prev;
        logic             pulse;
    } cnt_t;

    cnt_t c_d, c_q;

    function automatic logic [C_W-1:0] eff_div(input logic [CNT_W-1:0] v);
        return (v == '0) ? FULL_V : {1'b0, v};
    endfunction

    always_comb begin
        c_d           = c_q;
        c_d.pulse     = 1'b0;
        c_d.gate_prev = gate;
        if (load) begin
            c_d.div   = load_val;
            c_d.count = eff_div(load_val);
        end else if (gate && !c_q.gate_prev) begin
            c_d.count = eff_div(c_q.div);
        end else if (gate && en) begin
            if (c_q.count == ONE_V) begin
                c_d.pulse = 1'b1;
                c_d.count = eff_div(c_q.div);
            end else begin
                c_d.count = c_q.count - ONE_V;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{div: '0, count: FULL_V, gate_prev: 1'b1, pulse: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign pulse = c_q.pulse;

    // R2: output pulses are one clock wide
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.pulse |=> !c_q.pulse);

    // R8: a low gate freezes the count and blocks the output
    a_r8_gate_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !load) |=> $stable(c_q.count));

    a_r8_gate_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !c_q.pulse);

    // R2: the count never reaches zero
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r2_count_nonzero: assert (c_q.count != '0);
        end
    end

endmodule

// File: rtl/pacer_burst_seq.sv
module pacer_burst_seq
    import pacer_pkg::*;
#(
    parameter int DIFF_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             burst_en,
    input  logic             diff_mode,
    input  logic [LEN_W-1:0] len_code,
    input  logic             busy,
    input  logic             clr_ovr,
    output logic             start,
    output logic             overrun
);

    localparam logic [LEN_W-1:0] DIFF_CAP = LEN_W'(DIFF_MAX - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [LEN_W-1:0] rem;
        logic             start;
        logic             ovr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (clr_ovr) begin
            s_d.ovr = 1'b0;
        end
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (tick) begin
                    s_d.start = 1'b1;
                    if (burst_en) begin
                        s_d.rem = (diff_mode && (len_code > DIFF_CAP)) ? DIFF_CAP : len_code;
                        s_d.st  = SEQ_WAIT_HI;
                    end
                end
            end
            SEQ_WAIT_HI: begin
                if (tick) begin
                    s_d.ovr = 1'b1;
                end
                if (busy) begin
                    s_d.st = SEQ_WAIT_LO;
                end
            end
            SEQ_WAIT_LO: begin
                if (tick) begin
                    s_d.ovr = 1'b1;
                end
                if (!busy) begin
                    if (s_q.rem != '0) begin
                        s_d.start = 1'b1;
                        s_d.rem   = s_q.rem - 1'b1;
                        s_d.st    = SEQ_WAIT_HI;
                    end else begin
                        s_d.st = SEQ_IDLE;
                    end
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, rem: '0, start: 1'b0, ovr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign start   = s_q.start;
    assign overrun = s_q.ovr;

    // R5: no start while the converter is still busy
    a_r5_wait_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_WAIT_LO && busy) |=> !s_q.start);

    // R6: overrun is sticky until cleared
    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovr && !clr_ovr) |=> s_q.ovr);

    a_r6_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovr && !tick) |=> !s_q.ovr);

    // R6: a tick during a running burst issues nothing
    a_r6_tick_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_WAIT_HI && tick) |=> !s_q.start);

    // R4: differential bursts are capped
    a_r4_diff_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_IDLE && tick && burst_en && diff_mode) |=> (s_q.rem <= DIFF_CAP));

    // R7: outside burst mode a tick gives one start and no run
    a_r7_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_IDLE && tick && !burst_en) |=> (s_q.start && s_q.st == SEQ_IDLE));

endmodule

// File: rtl/adc_pacer_burst.sv
module adc_pacer_burst
    import pacer_pkg::*;
#(
    parameter int PRESCALE = 10,
    parameter int CNT_W    = 16,
    parameter int DIFF_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ext_clk_in,
    input  logic             ext_gate_in,
    input  logic             conv_busy,
    output logic             conv_start,
    output logic             aux_tick,
    output logic             overrun
);

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int N_CNT  = 3;

    typedef struct packed {
        ctrl_t ctrl;
        logic  aux_src_prev;
    } top_t;

    top_t t_d, t_q;

    logic             clk_s, gate_s;
    logic             fast_stb, ref_level;
    logic             aux_src, aux_stb, gate_eff, ctrl_wr;
    logic [N_CNT-1:0] en_v, gate_v, load_v, pulse_v;

    pacer_sync2 #(
        .WIDTH     (2),
        .RESET_VAL (2'b11)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_clk_in, ext_gate_in}),
        .q     ({clk_s, gate_s})
    );

    pacer_timebase #(
        .PRESCALE (PRESCALE)
    ) i_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_stb  (fast_stb),
        .ref_level (ref_level)
    );

    assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
    assign aux_src  = t_q.ctrl.aux_ref_and ? (ref_level & clk_s) : clk_s;
    assign aux_stb  = aux_src & ~t_q.aux_src_prev;
    assign gate_eff = t_q.ctrl.gate_ext ? gate_s : 1'b1;

    always_comb begin
        t_d              = t_q;
        t_d.aux_src_prev = aux_src;
        if (ctrl_wr) begin
            t_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{ctrl: '0, aux_src_prev: 1'b1};
        end else begin
            t_q <= t_d;
        end
    end

    // counter 0 and 1 form the pacer cascade, counter 2 is the auxiliary channel
    assign en_v   = {aux_stb, pulse_v[0], fast_stb};
    assign gate_v = {1'b1, gate_eff, gate_eff};

    for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
        assign load_v[gi] = wr_en && (wr_addr == 2'(gi + 1));
        pacer_rate_counter #(
            .CNT_W (CNT_W)
        ) i_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_v[gi]),
            .gate     (gate_v[gi]),
            .load     (load_v[gi]),
            .load_val (wr_data),
            .pulse    (pulse_v[gi])
        );
    end

    pacer_burst_seq #(
        .DIFF_MAX (DIFF_MAX)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (pulse_v[1]),
        .burst_en  (t_q.ctrl.burst_en),
        .diff_mode (t_q.ctrl.diff_mode),
        .len_code  (t_q.ctrl.burst_len),
        .busy      (conv_busy),
        .clr_ovr   (ctrl_wr),
        .start     (conv_start),
        .overrun   (overrun)
    );

    assign aux_tick = pulse_v[2];

    // R2: conversion starts are never back to back
    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R12: blocked reference with a low pin yields no auxiliary strobe
    a_r12_aux_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.ctrl.aux_ref_and && !clk_s) |-> !aux_stb);

    // R9: with external gating off, the pacer gate is high
    a_r9_gate_tied: assert property (@(posedge clk) disable iff (!rst_n)
        (!t_q.ctrl.gate_ext && !gate_s) |-> gate_v[1]);

endmodule

// File: tb/test_adc_pacer_burst.sv
module test_adc_pacer_burst;

    localparam int PS      = 10;
    localparam int WD_MAX  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        ext_clk_in = 1'b1;
    logic        ext_gate_in = 1'b0;
    logic        conv_busy = 1'b0;
    logic        conv_start, aux_tick, overrun;

    int tests = 0, fails = 0;
    int cyc = 0, n_start = 0, n_aux = 0, viol = 0;
    int last_start = 0, start_gap = 0, last_aux = 0, aux_gap = 0;
    int bcnt = 0;

    always #10 clk = ~clk;

    adc_pacer_burst i_adc_pacer_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ext_clk_in  (ext_clk_in),
        .ext_gate_in (ext_gate_in),
        .conv_busy   (conv_busy),
        .conv_start  (conv_start),
        .aux_tick    (aux_tick),
        .overrun     (overrun)
    );

    // converter model and output monitor, away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && conv_start) begin
            if (conv_busy) viol = viol + 1;
            n_start    = n_start + 1;
            start_gap  = cyc - last_start;
            last_start = cyc;
            conv_busy  = 1'b1;
            bcnt       = 5;
        end else if (bcnt > 0) begin
            if (bcnt == 1) conv_busy = 1'b0;
            bcnt = bcnt - 1;
        end
        if (rst_n && aux_tick) begin
            n_aux    = n_aux + 1;
            aux_gap  = cyc - last_aux;
            last_aux = cyc;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // hold pacer via gate (ext_gate_in low), load divisors, release, count 3.5 periods
    task automatic pace_run(input logic [7:0] ctrl, input int da, input int db,
                            output int got, output int gap);
        int base;
        int per;
        per = PS * da * db;
        wr(2'd0, {8'd0, ctrl | 8'h02});
        wait_cyc(150);
        wr(2'd1, 16'(da));
        wr(2'd2, 16'(db));
        base = n_start;
        wr(2'd0, {8'd0, ctrl & 8'hFD});
        wait_cyc(3 * per + per / 2);
        got = n_start - base;
        gap = start_gap;
        wr(2'd0, {8'd0, ctrl | 8'h02});
    endtask

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] da;
        logic [15:0] db;
        logic [7:0]  per_tick;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 16'd4, 16'd10, 8'd1},   // R2 single conversions
        '{8'hF0, 16'd4, 16'd10, 8'd1},   // R7 length code ignored
        '{8'h04, 16'd4, 16'd10, 8'd1},   // R3 code 0 -> 1
        '{8'h34, 16'd4, 16'd10, 8'd4},   // R3 code 3 -> 4
        '{8'hF4, 16'd4, 16'd10, 8'd16},  // R3 code 15 -> 16
        '{8'hFC, 16'd4, 16'd10, 8'd8},   // R4 differential cap
        '{8'h2C, 16'd4, 16'd10, 8'd3}    // R4 differential below cap
    };

    initial begin
        wait_cyc(WD_MAX);
        tests = tests + 1;
        fails = fails + 1;
        $display("FAIL watchdog all requirements actual=%0d expected<%0d", cyc, WD_MAX);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int got, gap, base;
        string tag;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 reset state
        check("R1 conv_start", int'(conv_start), 0);
        check("R1 aux_tick", int'(aux_tick), 0);
        check("R1 overrun", int'(overrun), 0);

        // table walk; ext_gate_in stays low, gating disabled in each window
        for (int i = 0; i < NV; i++) begin
            pace_run(VEC[i].ctrl, int'(VEC[i].da), int'(VEC[i].db), got, gap);
            if (!VEC[i].ctrl[2]) tag = (VEC[i].ctrl[7:4] != 4'd0) ? "R7" : "R2";
            else tag = VEC[i].ctrl[3] ? "R4" : "R3";
            check(tag, got, 3 * int'(VEC[i].per_tick));
            if (i == 0) check("R2 period", gap, PS * 4 * 10);
        end
        check("R5 start while busy", viol, 0);

        // R9: gate pin low but external gating off
        pace_run(8'h00, 2, 5, got, gap);
        check("R9 count", got, 3);
        check("R2 short period", gap, 100);

        // R8: external gating on
        wr(2'd0, 16'h0002);
        wr(2'd1, 16'd4);
        wr(2'd2, 16'd10);
        base = n_start;
        wait_cyc(1400);
        check("R8 held", n_start - base, 0);
        base = n_start;
        ext_gate_in = 1'b1;
        wait_cyc(1400);
        check("R8 resumed", n_start - base, 3);
        check("R8 period", start_gap, 400);
        ext_gate_in = 1'b0;

        // R6: overrun with a short pacer period and long bursts
        wr(2'd0, 16'h00F6);
        wait_cyc(150);
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd2);
        wr(2'd0, 16'h00F4);
        wait_cyc(400);
        check("R6 set", int'(overrun), 1);
        wr(2'd0, 16'h00F6);
        wait_cyc(200);
        check("R6 cleared", int'(overrun), 0);

        // R10: reference passed by a high pin
        wr(2'd0, 16'h0003);
        ext_clk_in = 1'b1;
        wr(2'd3, 16'd3);
        base = n_aux;
        wait_cyc(1050);
        check("R10 count", n_aux - base, 3);
        check("R10 period", aux_gap, PS * PS * 3);

        // R12: low pin blocks the reference
        ext_clk_in = 1'b0;
        wait_cyc(5);
        base = n_aux;
        wait_cyc(1050);
        check("R12 blocked", n_aux - base, 0);

        // R11: raw pin mode
        wr(2'd0, 16'h0002);
        ext_clk_in = 1'b1;
        wait_cyc(20);
        base = n_aux;
        wait_cyc(500);
        check("R11 steady pin", n_aux - base, 0);
        wr(2'd3, 16'd4);
        base = n_aux;
        ext_clk_in = 1'b0;
        for (int k = 0; k < 28; k++) begin
            wait_cyc(8);
            ext_clk_in = ~ext_clk_in;
        end
        wait_cyc(4);
        check("R11 pin edges", n_aux - base, 3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule